// File: doc/BRIEF.md
# Serial Frame Transmitter with Phase-Tick Timing

This block turns bytes written by a host into a serial bit stream. It does not divide the bit rate itself. A separate rate generator supplies a one-cycle tick strobe. In asynchronous mode each bit lasts sixteen ticks, and a 4-bit phase counter decides where within the bit the line and the optional clock pin move. In clocked-synchronous mode each bit takes two ticks: a falling one, where the data changes, and a rising one.

An asynchronous frame has these parts, in order:
- a low start bit;
- 7 or 8 data bits, least significant first;
- optionally one extra bit, which is either parity or a multiprocessor address flag taken from an input;
- one or two high stop bits.

The host writes into a single holding register, and an empty flag shows when that register is free. When a byte is waiting at the end of the last stop bit, the next frame starts straight away with no idle time. Otherwise the line stays high for one more bit period in a final state. After that the transmit-end flag rises and an optional one-cycle interrupt pulse is issued. The clock is `clk`, and `rst` is a synchronous active-high reset.

Top module: `serial_tx_engine`

## Requirements
- R1: After reset, `txd_o`=1, `sclk_o`=1, `empty_o`=1, `tend_o`=1 and `tend_irq_o`=0.
- R2: A host write (`wr_i`=1) clears `empty_o` on the next clock. Moving the byte into the shifter sets `empty_o` again. This move happens one clock after the write when the block is idle and enabled, or at a chained frame start.
- R3: Starting a frame presets the phase counter to 15, so the first tick wraps it to 0 and drives the start bit (0) at once. After that, every bit lasts exactly 16 ticks, and `txd_o` changes only on the tick that brings the phase to 0. No tick means no output change.
- R4: Data bits go out least significant bit first. With `seven_bit_i`=1, only bits 6..0 are sent and bit 7 of the written byte is ignored.
- R5: With `parity_en_i`=1 (and `mp_en_i`=0), one parity bit follows the data. The parity bit is the XOR of the sent data bits, inverted when `parity_odd_i`=1.
- R6: With `mp_en_i`=1, the extra bit after the data carries the value of `mp_bit_i`. This takes precedence over parity.
- R7: One stop bit at 1 follows, or two when `two_stop_i`=1. During the final state after the last stop bit, the line remains 1.
- R8: When a byte is waiting (`empty_o`=0, `tx_en_i`=1) at the last stop bit, its start bit follows on the very next phase-0 tick. No idle bit is inserted and `tend_o` stays 0.
- R9: When nothing is waiting, one full bit period after the last stop bit began, `tend_o` rises. `tend_irq_o` pulses for one cycle at the same time if `tend_ie_i`=1, and does not pulse otherwise. A new frame clears `tend_o`.
- R10: With `clk_out_en_i`=1 in asynchronous mode, `sclk_o` goes low at phase 0 and high at phase 8 of every bit. `sclk_o` is 1 whenever no frame is active, and it is always 1 when `clk_out_en_i`=0.
- R11: With `sync_mode_i`=1, exactly 8 bits go out least significant bit first with no start, parity or stop bits. Odd-numbered ticks after the start are falling ticks: they change the data and drive `sclk_o` low. Even-numbered ticks drive `sclk_o` high. The tick after the last bit's period returns `txd_o` to 1 and sets `tend_o`.
- R12: While `tx_en_i`=0, a written byte stays in the holding register (`empty_o`=0), and ticks leave `txd_o` at 1 and `tend_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle timing tick from the rate generator |
| tx_en_i | input | 1 | Allows bytes to be taken from the holding register |
| sync_mode_i | input | 1 | 1 = clocked-synchronous mode, 0 = asynchronous frames |
| seven_bit_i | input | 1 | 1 = 7 data bits in asynchronous mode |
| parity_en_i | input | 1 | Adds a parity bit |
| parity_odd_i | input | 1 | 1 = odd parity, 0 = even |
| mp_en_i | input | 1 | Adds a multiprocessor flag bit |
| mp_bit_i | input | 1 | Value of the multiprocessor flag bit |
| two_stop_i | input | 1 | 1 = two stop bits |
| clk_out_en_i | input | 1 | Drives the bit clock on `sclk_o` |
| tend_ie_i | input | 1 | Enables the transmit-end interrupt pulse |
| wr_i | input | 1 | Host write strobe for the holding register |
| wr_data_i | input | 8 | Byte to send |
| txd_o | output | 1 | Serial data line |
| sclk_o | output | 1 | Bit clock output |
| empty_o | output | 1 | Holding register free |
| tend_o | output | 1 | Transmit end flag |
| tend_irq_o | output | 1 | One-cycle transmit-end interrupt |

## Verification
The asynchronous engine is tested with several frame shapes:
- plain 8-bit frames with one stop bit and the clock pin disabled;
- 7-bit frames with even parity and two stop bits, using a byte whose top bit is set to prove that bit is dropped;
- odd parity on an all-zero byte, which makes the parity bit differ from the even answer;
- a multiprocessor frame with parity also enabled, to show which extra bit wins.

The line is sampled at phases 0, 7, 8 and 15 of every bit. This separates a wrong bit value from a wrong bit length and from a wrong clock edge. Two back-to-back bytes with interrupts enabled show that the frames are joined without a gap and raise one transmit-end event, not two. A byte written while transmission is disabled, and a synchronous byte with an irregular bit pattern, complete the set.

// File: rtl/stx_pkg.sv
package stx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_EXTRA,
    ST_STOP,
    ST_LAST
  } tx_state_e;
endpackage

// File: rtl/stx_holding.sv
module stx_holding #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              load_i,
  output logic [DATA_W-1:0] hold_o,
  output logic              empty_o
);
  logic [DATA_W-1:0] hold_q;
  logic              empty_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      empty_q <= 1'b1;
    end else if (wr_i) begin
      hold_q  <= wr_data_i;
      empty_q <= 1'b0;
    end else if (load_i) begin
      empty_q <= 1'b1;
    end
  end

  assign hold_o  = hold_q;
  assign empty_o = empty_q;

  a_r2_write_clears: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> !empty_q);
  a_r2_load_sets: assert property (@(posedge clk) disable iff (rst)
    (load_i && !wr_i) |=> empty_q);
endmodule

// File: rtl/stx_phase.sv
module stx_phase #(
  parameter int PHASES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic run_i,
  input  logic preset_i,
  input  logic sync_i,
  output logic step_o,
  output logic half_o
);
  localparam int PH_W = $clog2(PHASES);
  localparam logic [PH_W-1:0] PH_TOP  = PH_W'(PHASES - 1);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(PHASES / 2);
  localparam logic [PH_W-1:0] PH_ONE  = PH_W'(1);

  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] phase_nxt;
  logic            adv;

  always_comb begin
    if (sync_i) phase_nxt = (phase_q == '0) ? PH_ONE : '0;
    else        phase_nxt = phase_q + PH_ONE;
  end

  assign adv    = tick_i & run_i;
  assign step_o = adv & (phase_nxt == '0);
  assign half_o = adv & (phase_nxt == (sync_i ? PH_ONE : PH_HALF));

  always_ff @(posedge clk) begin
    if (rst || preset_i) phase_q <= PH_TOP;
    else if (adv)        phase_q <= phase_nxt;
  end

  a_r3_idle_no_step: assert property (@(posedge clk) disable iff (rst)
    !run_i |-> !step_o && !half_o);
endmodule

// File: rtl/stx_frame.sv
module stx_frame
  import stx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_i,
  input  logic              enable_i,
  input  logic              empty_i,
  input  logic [DATA_W-1:0] hold_i,
  input  logic              sync_i,
  input  logic              seven_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              mp_en_i,
  input  logic              mp_bit_i,
  input  logic              two_stop_i,
  input  logic              tend_ie_i,
  output logic              load_o,
  output logic              start_o,
  output logic              busy_o,
  output logic              fin_o,
  output logic              txd_o,
  output logic              tend_o,
  output logic              irq_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  tx_state_e         state_q;
  logic [DATA_W-1:0] shift_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              par_q;
  logic              extra_stop_q;
  logic              txd_q;
  logic              tend_q;
  logic              irq_q;

  logic              can_load;
  logic              idle_start;
  logic              frame_end;
  logic              chain;
  logic [DATA_W-1:0] mask;
  logic [CNT_W-1:0]  nbits;

  assign can_load   = enable_i & ~empty_i;
  assign idle_start = (state_q == ST_IDLE) & can_load;
  assign frame_end  = step_i & (sync_i ? (state_q == ST_DATA && cnt_q == CNT_ONE)
                                       : (state_q == ST_STOP && !extra_stop_q));
  assign chain      = frame_end & can_load;
  assign load_o     = idle_start | chain;
  assign start_o    = idle_start;
  assign busy_o     = (state_q != ST_IDLE);
  assign fin_o      = step_i & (state_q == ST_LAST);
  assign mask       = {~(seven_i & ~sync_i), {(DATA_W-1){1'b1}}};
  assign nbits      = (seven_i && !sync_i) ? CNT_W'(DATA_W - 1) : CNT_W'(DATA_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      shift_q      <= '0;
      cnt_q        <= '0;
      par_q        <= 1'b0;
      extra_stop_q <= 1'b0;
      txd_q        <= 1'b1;
      tend_q       <= 1'b1;
      irq_q        <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (idle_start) begin
        state_q <= sync_i ? ST_DATA : ST_START;
      end else if (step_i) begin
        case (state_q)
          ST_START: begin
            txd_q   <= 1'b0;
            state_q <= ST_DATA;
          end
          ST_DATA: begin
            txd_q   <= shift_q[0];
            shift_q <= shift_q >> 1;
            cnt_q   <= cnt_q - CNT_ONE;
            if (cnt_q == CNT_ONE) begin
              extra_stop_q <= two_stop_i;
              if (sync_i)                  state_q <= chain ? ST_DATA : ST_LAST;
              else if (par_en_i || mp_en_i) state_q <= ST_EXTRA;
              else                         state_q <= ST_STOP;
            end
          end
          ST_EXTRA: begin
            txd_q        <= mp_en_i ? mp_bit_i : par_q;
            extra_stop_q <= two_stop_i;
            state_q      <= ST_STOP;
          end
          ST_STOP: begin
            txd_q <= 1'b1;
            if (extra_stop_q) extra_stop_q <= 1'b0;
            else              state_q <= chain ? ST_START : ST_LAST;
          end
          ST_LAST: begin
            txd_q   <= 1'b1;
            tend_q  <= 1'b1;
            irq_q   <= tend_ie_i;
            state_q <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
      if (load_o) begin
        shift_q <= hold_i;
        cnt_q   <= nbits;
        par_q   <= (^(hold_i & mask)) ^ par_odd_i;
        tend_q  <= 1'b0;
      end
    end
  end

  assign txd_o  = txd_q;
  assign tend_o = tend_q;
  assign irq_o  = irq_q;

  a_r3_txd_moves_on_step: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(txd_q));
  a_r7_last_line_high: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LAST && !sync_i) |-> txd_q);
  a_r9_irq_with_tend: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> tend_q);
endmodule

// File: rtl/serial_tx_engine.sv
module serial_tx_engine #(
  parameter int DATA_W = 8,
  parameter int PHASES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              tx_en_i,
  input  logic              sync_mode_i,
  input  logic              seven_bit_i,
  input  logic              parity_en_i,
  input  logic              parity_odd_i,
  input  logic              mp_en_i,
  input  logic              mp_bit_i,
  input  logic              two_stop_i,
  input  logic              clk_out_en_i,
  input  logic              tend_ie_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              txd_o,
  output logic              sclk_o,
  output logic              empty_o,
  output logic              tend_o,
  output logic              tend_irq_o
);
  logic [DATA_W-1:0] hold;
  logic              empty;
  logic              load;
  logic              start;
  logic              busy;
  logic              fin;
  logic              step;
  logic              half;
  logic              sclk_q;

  stx_holding #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .wr_i(wr_i), .wr_data_i(wr_data_i),
    .load_i(load), .hold_o(hold), .empty_o(empty)
  );

  stx_phase #(.PHASES(PHASES)) u_phase (
    .clk(clk), .rst(rst), .tick_i(tick_i), .run_i(busy), .preset_i(start),
    .sync_i(sync_mode_i), .step_o(step), .half_o(half)
  );

  stx_frame #(.DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst(rst), .step_i(step), .enable_i(tx_en_i), .empty_i(empty),
    .hold_i(hold), .sync_i(sync_mode_i), .seven_i(seven_bit_i),
    .par_en_i(parity_en_i), .par_odd_i(parity_odd_i), .mp_en_i(mp_en_i),
    .mp_bit_i(mp_bit_i), .two_stop_i(two_stop_i), .tend_ie_i(tend_ie_i),
    .load_o(load), .start_o(start), .busy_o(busy), .fin_o(fin),
    .txd_o(txd_o), .tend_o(tend_o), .irq_o(tend_irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst)                          sclk_q <= 1'b1;
    else if (!clk_out_en_i || !busy)  sclk_q <= 1'b1;
    else if (fin)                     sclk_q <= 1'b1;
    else if (step)                    sclk_q <= 1'b0;
    else if (half)                    sclk_q <= 1'b1;
  end

  assign sclk_o  = sclk_q;
  assign empty_o = empty;

  a_r10_idle_clock_high: assert property (@(posedge clk) disable iff (rst)
    !busy |-> sclk_o);
  a_r12_disabled_no_load: assert property (@(posedge clk) disable iff (rst)
    !tx_en_i |-> !load);
endmodule

// File: tb/serial_tx_engine_test.sv
module serial_tx_engine_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 0, tx_en = 1, sync_m = 0, seven = 0, par_en = 0, par_odd = 0;
  logic mp_en = 0, mp_bit = 0, two_stop = 0, clk_out = 0, tend_ie = 0, wr = 0;
  logic [7:0] wr_data = 0;
  logic txd, sclk, empty, tend, irq;
  int n_chk = 0, n_fail = 0, irq_cnt = 0;

  always #4 clk = ~clk;

  serial_tx_engine uut (
    .clk(clk), .rst(rst), .tick_i(tick), .tx_en_i(tx_en), .sync_mode_i(sync_m),
    .seven_bit_i(seven), .parity_en_i(par_en), .parity_odd_i(par_odd),
    .mp_en_i(mp_en), .mp_bit_i(mp_bit), .two_stop_i(two_stop),
    .clk_out_en_i(clk_out), .tend_ie_i(tend_ie), .wr_i(wr), .wr_data_i(wr_data),
    .txd_o(txd), .sclk_o(sclk), .empty_o(empty), .tend_o(tend), .tend_irq_o(irq)
  );

  always @(posedge clk) if (!rst && irq) irq_cnt++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic host_write(input logic [7:0] d);
    @(negedge clk) begin wr = 1'b1; wr_data = d; end
    @(negedge clk) wr = 1'b0;
  endtask

  // Expected asynchronous frame, built from the requirements.
  task automatic build(input logic [7:0] d, output logic [15:0] b, output int n,
                       output string tg [16]);
    int nb;
    n = 0; b = '0;
    b[n] = 1'b0; tg[n] = "R3 start"; n++;
    nb = seven ? 7 : 8;
    for (int k = 0; k < nb; k++) begin b[n] = d[k]; tg[n] = "R4 data"; n++; end
    if (mp_en) begin b[n] = mp_bit; tg[n] = "R6 mp"; n++; end
    else if (par_en) begin
      b[n] = (seven ? ^d[6:0] : ^d) ^ par_odd; tg[n] = "R5 parity"; n++;
    end
    b[n] = 1'b1; tg[n] = "R7 stop"; n++;
    if (two_stop) begin b[n] = 1'b1; tg[n] = "R7 stop2"; n++; end
  endtask

  task automatic run_async(input logic [7:0] d, input bit last);
    logic [15:0] b; int n; string tg [16];
    build(d, b, n, tg);
    for (int i = 0; i < n; i++) begin
      pulse();
      check(tg[i], txd, b[i]);
      check("R10 clk phase0", sclk, clk_out ? 1'b0 : 1'b1);
      if (i == 0) check("R8/R9 tend low in frame", tend, 0);
      repeat (7) pulse();
      check({tg[i], " R3 hold"}, txd, b[i]);
      check("R10 clk phase7", sclk, clk_out ? 1'b0 : 1'b1);
      pulse();
      check("R10 clk phase8", sclk, 1'b1);
      repeat (7) pulse();
      check({tg[i], " R3 phase15"}, txd, b[i]);
    end
    if (last) begin
      check("R9 tend before last tick", tend, 0);
      pulse();
      check("R9 tend set", tend, 1);
      check("R7 line high at end", txd, 1);
      check("R10 clk idle high", sclk, 1);
    end
  endtask

  task automatic t_reset();
    check("R1 txd", txd, 1); check("R1 sclk", sclk, 1);
    check("R1 empty", empty, 1); check("R1 tend", tend, 1); check("R1 irq", irq, 0);
  endtask

  task automatic t_plain();
    host_write(8'hA5);
    check("R2 write clears empty", empty, 0);
    @(negedge clk);
    check("R2 load sets empty", empty, 1);
    repeat (3) @(negedge clk);
    check("R3 no output before tick", txd, 1);
    run_async(8'hA5, 1);
    check("R9 no irq when disabled", irq_cnt, 0);
  endtask

  task automatic t_seven_par();
    seven = 1; par_en = 1; two_stop = 1; clk_out = 1;
    host_write(8'hD3); repeat (2) @(negedge clk);
    run_async(8'hD3, 1);
    seven = 0; two_stop = 0;
  endtask

  task automatic t_odd();
    par_odd = 1;
    host_write(8'h00); repeat (2) @(negedge clk);
    run_async(8'h00, 1);
    par_odd = 0; par_en = 0;
  endtask

  task automatic t_mp();
    mp_en = 1; mp_bit = 1; par_en = 1;
    host_write(8'h3C); repeat (2) @(negedge clk);
    run_async(8'h3C, 1);
    mp_en = 0; mp_bit = 0; par_en = 0;
  endtask

  task automatic t_chain();
    int base;
    tend_ie = 1; base = irq_cnt;
    host_write(8'h81); @(negedge clk);
    host_write(8'h5E);
    check("R2 second byte waiting", empty, 0);
    run_async(8'h81, 0);
    run_async(8'h5E, 1);
    check("R2 chained byte taken", empty, 1);
    @(negedge clk);
    check("R9 single irq for chain", irq_cnt - base, 1);
    tend_ie = 0;
  endtask

  task automatic t_disabled();
    tx_en = 0;
    host_write(8'h77);
    repeat (20) pulse();
    check("R12 line idle", txd, 1);
    check("R12 byte kept", empty, 0);
    check("R12 tend unchanged", tend, 1);
    tx_en = 1; repeat (2) @(negedge clk);
    run_async(8'h77, 1);
  endtask

  task automatic t_sync();
    logic [7:0] d = 8'h96;
    int base = irq_cnt;
    sync_m = 1; clk_out = 1;
    host_write(d); repeat (2) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      pulse();
      check("R11 sync bit", txd, d[k]);
      check("R11 sync clk low", sclk, 0);
      pulse();
      check("R11 sync clk high", sclk, 1);
      check("R11 sync bit hold", txd, d[k]);
    end
    check("R11 tend before end", tend, 0);
    pulse();
    check("R11 line high", txd, 1);
    check("R11 tend", tend, 1);
    check("R11 clk idle", sclk, 1);
    check("R9 no irq sync", irq_cnt - base, 0);
    sync_m = 0; clk_out = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_plain();
    t_seven_par();
    t_odd();
    t_mp();
    t_chain();
    t_disabled();
    t_sync();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule